// File: doc/BRIEF.md
# Multi-Channel Bidirectional Pulse Timer

This block holds a bank of identical, independent timing channels. Each channel owns one digital pin. A per-channel direction bit selects its job. As a generator, the channel drives the pin high for a programmed number of clock ticks, then low for a second programmed number, and repeats for as long as it stays in that mode. As a meter, it samples the pin on every clock. It counts how long the signal stays at each level and keeps the most recent high-level and low-level durations in two readable result registers.

The control side is a plain register-style port. It carries the direction bits, a pair of tick counts per channel, and the two measured durations per channel. All quantities are unsigned integer tick counts of `CNT_W` bits. The host converts frequency and duty cycle into these counts outside the block.

Top module: `pwm_bank`

## Requirements
- R1: A synchronous active-high reset drives every `pin_o` bit low and every `pin_oe` bit high, which is generator mode. It also zeroes both result registers of every channel.
- R2: A direction bit of 0 makes the channel a generator with `pin_oe` = 1. A direction bit of 1 makes it a meter with `pin_oe` = 0 and `pin_o` = 0. Both take effect one clock after the bit is presented.
- R3: A generator with non-zero high count H and low count L drives `pin_o` high for exactly H clocks, then low for exactly L clocks, and repeats. Starting from idle (after reset or a mode change), the high phase begins on the first clock edge.
- R4: A generator samples the high and low counts only at the last tick of a phase, or while idle. A rewrite in the middle of a phase changes neither that phase's length nor its level.
- R5: A count of zero removes that phase from the cycle, so the pin stays at the other level continuously. When both counts are zero, the pin is held low.
- R6: In meter mode the pin passes through a two-flop synchronizer, followed by one more flop used for edge detection. A falling edge stores the number of ticks the synchronized signal was high into the high result. A rising edge stores the low-tick count into the low result. The first edge after entering meter mode only arms the meter and stores nothing.
- R7: The meter's running count saturates at 2^`CNT_W`−1 and does not wrap. A phase longer than that is reported as 2^`CNT_W`−1.
- R8: Changing a channel's direction clears that channel's generator state and its running count in the same clock in which the change is seen. Both result registers keep their values across the change.
- R9: Channels are independent. The settings, pin and direction of one channel never affect another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins are sampled on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | NUM_CH | Direction bit per channel (0 = generate, 1 = measure) |
| hi_ticks_i | input | NUM_CH*CNT_W | High-phase tick count per channel, channel c at bits [c*CNT_W +: CNT_W] |
| lo_ticks_i | input | NUM_CH*CNT_W | Low-phase tick count per channel, same packing |
| pin_i | input | NUM_CH | Pin level seen by each channel |
| pin_o | output | NUM_CH | Pin level driven by each channel |
| pin_oe | output | NUM_CH | Pin drive enable per channel (1 = channel drives the pin) |
| hi_meas_o | output | NUM_CH*CNT_W | Last measured high duration per channel, same packing |
| lo_meas_o | output | NUM_CH*CNT_W | Last measured low duration per channel, same packing |

## Verification
Two pairs of events can land in the same cycle. The first is a phase boundary and a rewrite of the tick counts. The bench changes the counts on a range of cycle offsets, so some rewrites fall on the last tick of a phase and others fall mid-phase. A cycle-accurate behavioural model decides which value must be picked up. The second pair is a direction flip and a phase end or input edge: the bench flips the direction bit at several offsets while the generator is running and while an edge is travelling through the synchronizer. On every clock, the model's pin levels, enables and both result registers are compared with the design's.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } lvl_e;

   function automatic int unsigned min_sync_stages();
      return 2;
   endfunction

endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pwm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic [CNT_W-1:0] hi_i,
   input  logic [CNT_W-1:0] lo_i,
   output logic             level_o
);
   generate
      if (CNT_W < 2) begin : g_bad
         $error("pwm_gen: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   lvl_e             lvl_q, nxt_lvl;
   logic [CNT_W-1:0] left_q, nxt_left;
   logic             at_edge;
   logic             hi_nz, lo_nz;

   assign at_edge = (left_q <= ONE);
   assign hi_nz   = (hi_i != '0);
   assign lo_nz   = (lo_i != '0);

   always_comb begin
      nxt_lvl  = LVL_LOW;
      nxt_left = '0;
      if (lvl_q == LVL_HIGH) begin
         if (lo_nz) begin
            nxt_lvl  = LVL_LOW;
            nxt_left = lo_i;
         end else if (hi_nz) begin
            nxt_lvl  = LVL_HIGH;
            nxt_left = hi_i;
         end
      end else begin
         if (hi_nz) begin
            nxt_lvl  = LVL_HIGH;
            nxt_left = hi_i;
         end else if (lo_nz) begin
            nxt_lvl  = LVL_LOW;
            nxt_left = lo_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         lvl_q  <= LVL_LOW;
         left_q <= '0;
      end else if (!at_edge) begin
         left_q <= left_q - ONE;
      end else begin
         lvl_q  <= nxt_lvl;
         left_q <= nxt_left;
      end
   end

   assign level_o = (lvl_q == LVL_HIGH);

   // R4
   mid_phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !at_edge) |=> $stable(lvl_q));

   // R5
   both_zero_low_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && at_edge && !hi_nz && !lo_nz) |=> (lvl_q == LVL_LOW));

   // R3
   phase_load_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && at_edge && hi_nz && lvl_q == LVL_LOW) |=> (lvl_q == LVL_HIGH));
endmodule

// File: rtl/pwm_meas.sv
module pwm_meas
   import pwm_bank_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             pin_i,
   output logic [CNT_W-1:0] hi_o,
   output logic [CNT_W-1:0] lo_o
);
   generate
      if (SYNC_STAGES < int'(min_sync_stages())) begin : g_bad
         $error("pwm_meas: synchronizer too short");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic             s_now, s_prev;
   logic             armed_q;
   logic [CNT_W-1:0] run_q, hi_q, lo_q;
   logic             edge_seen;

   pwm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (pin_i),
      .q_o (s_now)
   );

   assign edge_seen = (s_now != s_prev);

   always_ff @(posedge clk) begin
      if (rst) begin
         s_prev  <= 1'b0;
         armed_q <= 1'b0;
         run_q   <= '0;
         hi_q    <= '0;
         lo_q    <= '0;
      end else begin
         s_prev <= s_now;
         if (clr) begin
            armed_q <= 1'b0;
            run_q   <= '0;
         end else if (edge_seen) begin
            if (armed_q) begin
               if (s_prev) hi_q <= run_q;
               else        lo_q <= run_q;
            end
            armed_q <= 1'b1;
            run_q   <= ONE;
         end else if (run_q != CNT_MAX) begin
            run_q <= run_q + ONE;
         end
      end
   end

   assign hi_o = hi_q;
   assign lo_o = lo_q;

   // R7
   run_saturate_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !edge_seen && run_q == CNT_MAX) |=> (run_q == CNT_MAX));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!edge_seen) |=> ($stable(hi_q) && $stable(lo_q)));

   // R6
   unarmed_no_store_chk: assert property (@(posedge clk) disable iff (rst)
      (!armed_q) |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             meter_q,
   input  logic             flip,
   input  logic [CNT_W-1:0] hi_i,
   input  logic [CNT_W-1:0] lo_i,
   input  logic             pin_i,
   output logic             pin_o,
   output logic [CNT_W-1:0] hi_meas_o,
   output logic [CNT_W-1:0] lo_meas_o
);
   logic gen_clr, meas_clr;

   assign gen_clr  = flip | meter_q;
   assign meas_clr = flip | ~meter_q;

   pwm_gen #(.CNT_W(CNT_W)) u_gen (
      .clk     (clk),
      .rst     (rst),
      .clr     (gen_clr),
      .hi_i    (hi_i),
      .lo_i    (lo_i),
      .level_o (pin_o)
   );

   pwm_meas #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_meas (
      .clk   (clk),
      .rst   (rst),
      .clr   (meas_clr),
      .pin_i (pin_i),
      .hi_o  (hi_meas_o),
      .lo_o  (lo_meas_o)
   );
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
   parameter int NUM_CH      = 16,
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_CH-1:0]       mode_i,
   input  logic [NUM_CH*CNT_W-1:0] hi_ticks_i,
   input  logic [NUM_CH*CNT_W-1:0] lo_ticks_i,
   input  logic [NUM_CH-1:0]       pin_i,
   output logic [NUM_CH-1:0]       pin_o,
   output logic [NUM_CH-1:0]       pin_oe,
   output logic [NUM_CH*CNT_W-1:0] hi_meas_o,
   output logic [NUM_CH*CNT_W-1:0] lo_meas_o
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("pwm_bank: NUM_CH must be positive");
      end
   endgenerate

   logic [NUM_CH-1:0] mode_q;
   logic [NUM_CH-1:0] flip;

   assign flip = mode_i ^ mode_q;

   always_ff @(posedge clk) begin
      if (rst) mode_q <= '0;
      else     mode_q <= mode_i;
   end

   assign pin_oe = ~mode_q;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      pwm_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
         .clk       (clk),
         .rst       (rst),
         .meter_q   (mode_q[ch]),
         .flip      (flip[ch]),
         .hi_i      (hi_ticks_i[ch*CNT_W +: CNT_W]),
         .lo_i      (lo_ticks_i[ch*CNT_W +: CNT_W]),
         .pin_i     (pin_i[ch]),
         .pin_o     (pin_o[ch]),
         .hi_meas_o (hi_meas_o[ch*CNT_W +: CNT_W]),
         .lo_meas_o (lo_meas_o[ch*CNT_W +: CNT_W])
      );

      // R2
      meter_quiet_chk: assert property (@(posedge clk) disable iff (rst)
         mode_q[ch] |-> !pin_o[ch]);

      // R8
      flip_keeps_result_chk: assert property (@(posedge clk) disable iff (rst)
         flip[ch] |=> ($stable(hi_meas_o[ch*CNT_W +: CNT_W]) &&
                       $stable(lo_meas_o[ch*CNT_W +: CNT_W])));
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (pin_o == '0 && pin_oe == '1 && hi_meas_o == '0 && lo_meas_o == '0));
endmodule

// File: tb/pwm_bank_test.sv
module pwm_bank_test;
   localparam int NC = 4;
   localparam int CW = 8;
   localparam int MAXV = (1 << CW) - 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NC-1:0]    mode_i = '0;
   logic [NC*CW-1:0] hi_ticks_i = '0;
   logic [NC*CW-1:0] lo_ticks_i = '0;
   logic [NC-1:0]    pin_i = '0;
   logic [NC-1:0]    pin_o, pin_oe;
   logic [NC*CW-1:0] hi_meas_o, lo_meas_o;

   always #2.5 clk = ~clk;

   pwm_bank #(.NUM_CH(NC), .CNT_W(CW)) uut (
      .clk(clk), .rst(rst), .mode_i(mode_i),
      .hi_ticks_i(hi_ticks_i), .lo_ticks_i(lo_ticks_i),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
      .hi_meas_o(hi_meas_o), .lo_meas_o(lo_meas_o)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   string tag = "R1";

   // behavioural reference
   int m_mode[NC], m_lvl[NC], m_left[NC];
   int m_sy1[NC], m_sy2[NC], m_sy3[NC], m_arm[NC], m_run[NC], m_hi[NC], m_lo[NC];

   // pin stimulus for meter channels
   int d_hi[NC], d_lo[NC], d_cnt[NC], d_lvl[NC];

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic int hi_set(int c); return int'(hi_ticks_i[c*CW +: CW]); endfunction
   function automatic int lo_set(int c); return int'(lo_ticks_i[c*CW +: CW]); endfunction

   always @(posedge clk) begin
      cyc++;
      for (int c = 0; c < NC; c++) begin
         if (rst) begin
            m_mode[c] = 0; m_lvl[c] = 0; m_left[c] = 0;
            m_sy1[c] = 0; m_sy2[c] = 0; m_sy3[c] = 0;
            m_arm[c] = 0; m_run[c] = 0; m_hi[c] = 0; m_lo[c] = 0;
         end else begin
            int flip_now, old2, old3, h, l;
            flip_now = (int'(mode_i[c]) != m_mode[c]);
            h = hi_set(c); l = lo_set(c);
            if (flip_now || m_mode[c] == 1) begin
               m_lvl[c] = 0; m_left[c] = 0;
            end else if (m_left[c] > 1) begin
               m_left[c]--;
            end else begin
               if (m_lvl[c] == 1) begin
                  if (l != 0) begin m_lvl[c] = 0; m_left[c] = l; end
                  else if (h != 0) begin m_lvl[c] = 1; m_left[c] = h; end
                  else begin m_lvl[c] = 0; m_left[c] = 0; end
               end else begin
                  if (h != 0) begin m_lvl[c] = 1; m_left[c] = h; end
                  else if (l != 0) begin m_lvl[c] = 0; m_left[c] = l; end
                  else begin m_lvl[c] = 0; m_left[c] = 0; end
               end
            end
            old2 = m_sy2[c]; old3 = m_sy3[c];
            m_sy3[c] = old2; m_sy2[c] = m_sy1[c]; m_sy1[c] = int'(pin_i[c]);
            if (flip_now || m_mode[c] == 0) begin
               m_arm[c] = 0; m_run[c] = 0;
            end else if (old2 != old3) begin
               if (m_arm[c] == 1) begin
                  if (old3 == 1) m_hi[c] = m_run[c];
                  else           m_lo[c] = m_run[c];
               end
               m_arm[c] = 1; m_run[c] = 1;
            end else if (m_run[c] < MAXV) begin
               m_run[c]++;
            end
            m_mode[c] = int'(mode_i[c]);
         end
      end
   end

   always @(negedge clk) begin
      for (int c = 0; c < NC; c++) begin
         if (d_hi[c] == 0 && d_lo[c] == 0) continue;
         if (d_cnt[c] > 1) d_cnt[c]--;
         else begin
            d_lvl[c] = (d_lvl[c] == 1 && d_lo[c] != 0) ? 0 : ((d_hi[c] != 0) ? 1 : 0);
            d_cnt[c] = (d_lvl[c] == 1) ? d_hi[c] : d_lo[c];
         end
         pin_i[c] = d_lvl[c][0];
      end
   end

   always @(negedge clk) begin
      if (!rst && cyc > 0) begin
         for (int c = 0; c < NC; c++) begin
            check(tag, int'(pin_o[c]), m_lvl[c], $sformatf("pin_o[%0d]", c));
            check("R2", int'(pin_oe[c]), 1 - m_mode[c], $sformatf("pin_oe[%0d]", c));
            check(tag, int'(hi_meas_o[c*CW +: CW]), m_hi[c], $sformatf("hi_meas[%0d]", c));
            check(tag, int'(lo_meas_o[c*CW +: CW]), m_lo[c], $sformatf("lo_meas[%0d]", c));
         end
      end
   end

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   task automatic setc(int c, int h, int l);
      hi_ticks_i[c*CW +: CW] = CW'(h);
      lo_ticks_i[c*CW +: CW] = CW'(l);
   endtask

   task automatic drive(int c, int h, int l);
      d_hi[c] = h; d_lo[c] = l; d_cnt[c] = 1;
   endtask

   task automatic hold_pin(int c, int v);
      d_hi[c] = 0; d_lo[c] = 0; pin_i[c] = v[0];
   endtask

   initial begin
      for (int c = 0; c < NC; c++) begin d_hi[c] = 0; d_lo[c] = 0; d_cnt[c] = 0; d_lvl[c] = 0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      for (int c = 0; c < NC; c++) begin
         check("R1", int'(pin_o[c]), 0, "pin_o after reset");
         check("R1", int'(pin_oe[c]), 1, "pin_oe after reset");
         check("R1", int'(hi_meas_o[c*CW +: CW]), 0, "hi_meas after reset");
      end
      // R3 R5 R9: generators with mixed settings
      tag = "R3";
      setc(0, 3, 2); setc(1, 1, 1); setc(2, 0, 4); setc(3, 0, 0);
      rst = 1'b0;
      repeat (40) @(negedge clk);
      tag = "R5";
      check("R5", int'(pin_o[3]), 0, "both zero held low");
      check("R5", int'(pin_o[2]), 0, "zero high count stays low");
      setc(2, 5, 0);
      repeat (12) @(negedge clk);
      check("R5", int'(pin_o[2]), 1, "zero low count stays high");
      // R4: rewrites at assorted offsets
      tag = "R4";
      for (int k = 0; k < 9; k++) begin
         setc(0, 2 + k % 5, 1 + (k * 3) % 4);
         setc(1, 1 + k % 3, 2);
         repeat (k + 2) @(negedge clk);
      end
      repeat (20) @(negedge clk);
      // R9 R6: two channels become meters, two keep generating
      tag = "R6";
      drive(2, 5, 3); drive(3, 9, 4);
      mode_i[2] = 1'b1; mode_i[3] = 1'b1;
      repeat (80) @(negedge clk);
      check("R6", int'(hi_meas_o[2*CW +: CW]), 5, "measured high ch2");
      check("R6", int'(lo_meas_o[2*CW +: CW]), 3, "measured low ch2");
      check("R9", int'(hi_meas_o[3*CW +: CW]), 9, "measured high ch3");
      check("R9", int'(lo_meas_o[3*CW +: CW]), 4, "measured low ch3");
      // R7: long high phase saturates
      tag = "R7";
      hold_pin(3, 1);
      repeat (300) @(negedge clk);
      hold_pin(3, 0);
      repeat (10) @(negedge clk);
      check("R7", int'(hi_meas_o[3*CW +: CW]), MAXV, "saturated high");
      // R8: flip ch2 back to generating; results kept
      tag = "R8";
      setc(2, 4, 4);
      mode_i[2] = 1'b0;
      repeat (3) @(negedge clk);
      check("R8", int'(hi_meas_o[2*CW +: CW]), 5, "result kept after flip");
      // R8 R2: flips at many offsets against running generator and meter
      for (int k = 0; k < 12; k++) begin
         mode_i[2] = ~mode_i[2];
         drive(3, 2 + k % 3, 3);
         repeat (k % 5 + 1) @(negedge clk);
         mode_i[3] = ~mode_i[3];
         repeat (k % 7 + 3) @(negedge clk);
      end
      tag = "R2";
      mode_i = '0;
      repeat (30) @(negedge clk);
      finish_run();
   end
endmodule